// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial datapath of an SPI master. When enabled, it pulls one word at a time from a show-ahead transmit FIFO and shifts that word out on `mosi`, most significant bit first. While it shifts, it samples the returning line and pushes one received word into a receive FIFO for every word it sent. The SCLK rate is set outside the block. A separate divider supplies a one-cycle strobe, `sclk_tick`, and each strobe that arrives during a word produces one SCLK edge.

The configuration inputs are:
- clock polarity,
- clock phase,
- an internal loopback switch,
- the word length, coded as length minus one. Legal lengths run from 4 to 32 bits.

The configuration must be held stable while a word is in flight. Clearing `enable` abandons the current word and returns the engine to idle at once.

Top module: `spi_shift_engine`

## Requirements
- R1: Only the low N bits of the transmit word are sent, where N = `cfg_len_m1` + 1 and 4 <= N <= 32. They go out MSB first. A word takes exactly 2N active `sclk_tick` strobes, which gives N leading SCLK edges.
- R2: When `cfg_cpha`=0, the line is sampled on leading SCLK edges and `mosi` changes on trailing edges. When `cfg_cpha`=1, `mosi` changes on leading edges (except the first) and the line is sampled on trailing edges. A leading edge is one that moves SCLK away from `cfg_cpol`.
- R3: With `cfg_loop`=1, the received bits come from the outgoing `mosi` stream and `miso` has no effect.
- R4: `rx_data` carries the N received bits in its low bits, first bit received highest, with zeros above. It is valid in the cycle `rx_push` is high.
- R5: Each completed word gives exactly one single-cycle `rx_push`. Pushes never outnumber pops.
- R6: `tx_pop` pulses for one cycle, and a word starts only when the engine is idle, `enable`=1, `tx_empty`=0 and `rx_full`=0.
- R7: If `enable` is low in a cycle, then in the next cycle the engine is idle, `sclk` equals `cfg_cpol` and `rx_push` is low. An aborted word is never pushed, and the next word runs normally.
- R8: `busy` is high while a word is being shifted or while `tx_empty`=0, and low otherwise.
- R9: While idle, `sclk` rests at the `cfg_cpol` level, including straight after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low aborts and idles |
| cfg_loop | input | 1 | Internal loopback select |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | Sampling phase select |
| cfg_len_m1 | input | 5 | Word length minus one |
| sclk_tick | input | 1 | One-cycle SCLK edge strobe from the divider |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | 32 | Transmit FIFO head word |
| tx_pop | output | 1 | Take the head word |
| rx_full | input | 1 | Receive FIFO full |
| rx_push | output | 1 | Write `rx_data` into the receive FIFO |
| rx_data | output | 32 | Received word, zero-extended |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Shifting or transmit data pending |

## Verification
Some properties are checked on every cycle:
- pops are gated,
- pushes pair one-to-one with pops,
- pushes last a single cycle,
- received words are zero-extended,
- abort returns SCLK to rest,
- every active strobe toggles SCLK,
- `busy` rises after a pop.

Other behaviour depends on a model of the far end, so only the bench scenarios can show it:
- the bit order seen on the wire in all four clock modes,
- the number of SCLK edges per word length,
- the fact that loopback ignores `miso`,
- recovery after an abort.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef enum logic {
    ENG_IDLE  = 1'b0,
    ENG_SHIFT = 1'b1
  } eng_state_e;
endpackage

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
#(
  parameter int unsigned LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tx_empty,
  input  logic             rx_full,
  input  logic             sclk_tick,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [LEN_W-1:0] len_m1,
  output logic             load,
  output logic             shifting,
  output logic             sample_en,
  output logic             shift_en,
  output logic             sclk,
  output logic             word_done
);
  localparam int unsigned CNT_W = LEN_W + 1;

  eng_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic             done_q, done_d;
  logic             tick_act, lead, last;

  // edge decode
  always_comb begin
    shifting  = (st_q == ENG_SHIFT);
    load      = (st_q == ENG_IDLE) & enable & ~tx_empty & ~rx_full;
    tick_act  = shifting & enable & sclk_tick;
    lead      = ~cnt_q[0];
    sample_en = tick_act & (lead ^ cpha);
    shift_en  = tick_act & ~(lead ^ cpha) & (cnt_q != '0);
    last      = tick_act & (cnt_q == {len_m1, 1'b1});
  end

  // next state
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    done_d = 1'b0;
    unique case (st_q)
      ENG_IDLE: begin
        if (load) begin
          st_d   = ENG_SHIFT;
          cnt_d  = '0;
          sclk_d = cpol;
        end
      end
      ENG_SHIFT: begin
        if (!enable) begin
          st_d = ENG_IDLE;
        end else if (sclk_tick) begin
          sclk_d = ~sclk_q;
          cnt_d  = cnt_q + 1'b1;
          if (last) begin
            st_d   = ENG_IDLE;
            done_d = 1'b1;
          end
        end
      end
      default: st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      cnt_q  <= '0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
      done_q <= done_d;
    end
  end

  assign sclk      = shifting ? sclk_q : cpol;
  assign word_done = done_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    shifting |-> (cnt_q <= {len_m1, 1'b1})); // R1
  AST_TICK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (shifting && enable && sclk_tick) |=> (sclk != $past(sclk))); // R2
endmodule

// File: rtl/spi_eng_txsh.sv
module spi_eng_txsh #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift_en,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [LEN_W-1:0]  len_m1,
  output logic              mosi
);
  localparam logic [LEN_W:0] TOP_L = (LEN_W + 1)'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [LEN_W:0]    lsh;

  always_comb begin
    lsh  = TOP_L - {1'b0, len_m1};
    sh_d = sh_q;
    if (load) begin
      sh_d = tx_data << lsh;
    end else if (shift_en) begin
      sh_d = {sh_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign mosi = sh_q[DATA_W-1];
endmodule

// File: rtl/spi_eng_rxsh.sv
module spi_eng_rxsh #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              sample_en,
  input  logic              din,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load) begin
      sh_d = '0;
    end else if (sample_en) begin
      sh_d = {sh_q[DATA_W-2:0], din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rx_word = sh_q;
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int unsigned  DATA_W = 32,
  localparam int unsigned LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_loop,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [LEN_W-1:0]  cfg_len_m1,
  input  logic              sclk_tick,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pop,
  input  logic              rx_full,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              busy
);
  logic load, shifting, sample_en, shift_en, word_done, rx_bit;

  spi_eng_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tx_empty(tx_empty),
    .rx_full(rx_full), .sclk_tick(sclk_tick), .cpol(cfg_cpol), .cpha(cfg_cpha),
    .len_m1(cfg_len_m1), .load(load), .shifting(shifting),
    .sample_en(sample_en), .shift_en(shift_en), .sclk(sclk),
    .word_done(word_done)
  );

  spi_eng_txsh #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_txsh (
    .clk(clk), .rst_n(rst_n), .load(load), .shift_en(shift_en),
    .tx_data(tx_data), .len_m1(cfg_len_m1), .mosi(mosi)
  );

  assign rx_bit = cfg_loop ? mosi : miso;

  spi_eng_rxsh #(.DATA_W(DATA_W)) u_rxsh (
    .clk(clk), .rst_n(rst_n), .load(load), .sample_en(sample_en),
    .din(rx_bit), .rx_word(rx_data)
  );

  assign tx_pop  = load;
  assign rx_push = word_done;
  assign busy    = shifting | ~tx_empty;

  // word-in-flight tracker used only by the checks below
  logic pend_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pend_q <= 1'b0;
    else if (tx_pop)                pend_q <= 1'b1;
    else if (!enable || rx_push)    pend_q <= 1'b0;
  end

  AST_POP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> (enable && !tx_empty && !rx_full)); // R6
  AST_PUSH_NEEDS_POP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> pend_q); // R5
  AST_POP_NOT_STACKED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> (!pend_q || rx_push)); // R5
  AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rx_push); // R5
  AST_RX_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> ((rx_data >> ({1'b0, cfg_len_m1} + 1'b1)) == '0)); // R4
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ((sclk == cfg_cpol) && !rx_push)); // R7
  AST_BUSY_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> busy); // R8
endmodule

// File: tb/sim_spi_shift_engine.sv
module sim_spi_shift_engine;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 3;
  localparam int NV         = 8;

  typedef struct packed {
    logic        cpol;
    logic        cpha;
    logic        loop;
    logic [4:0]  lm1;
    logic [31:0] tx;
    logic [31:0] slv;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    {1'b0, 1'b0, 1'b0, 5'd7,  32'hFFFF_FFA5, 32'h0000_003C},
    {1'b0, 1'b1, 1'b0, 5'd15, 32'h1234_BEEF, 32'h0000_C0DE},
    {1'b1, 1'b0, 1'b0, 5'd31, 32'hDEAD_BEEF, 32'h8765_4321},
    {1'b1, 1'b1, 1'b0, 5'd3,  32'hFFFF_FFF9, 32'hFFFF_FFF6},
    {1'b0, 1'b0, 1'b1, 5'd12, 32'hFFFF_F5A3, 32'h0000_0AAA},
    {1'b1, 1'b1, 1'b1, 5'd31, 32'h0F1E_2D3C, 32'hFFFF_FFFF},
    {1'b0, 1'b1, 1'b0, 5'd4,  32'h0000_0015, 32'h0000_000A},
    {1'b1, 1'b0, 1'b1, 5'd3,  32'h0000_000C, 32'h0000_0003}
  };

  logic        clk = 1'b0;
  logic        rst_n, enable, cfg_loop, cfg_cpol, cfg_cpha;
  logic [4:0]  cfg_len_m1;
  logic        sclk_tick, tx_empty, tx_pop, rx_full, rx_push;
  logic [31:0] tx_data, rx_data;
  logic        sclk, mosi, busy;
  logic        miso = 1'b0;

  int nchk = 0;
  int nerr = 0;

  spi_shift_engine u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_loop(cfg_loop),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_len_m1(cfg_len_m1),
    .sclk_tick(sclk_tick), .tx_empty(tx_empty), .tx_data(tx_data),
    .tx_pop(tx_pop), .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // divider model
  int tdiv;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdiv      <= 0;
      sclk_tick <= 1'b0;
    end else begin
      tdiv      <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
      sclk_tick <= (tdiv == TICK_DIV-1);
    end
  end

  // transmit FIFO model (show-ahead)
  logic [31:0] txq [16];
  int txw = 0;
  int txr = 0;
  assign tx_empty = (txw == txr);
  assign tx_data  = txq[txr % 16];
  always @(posedge clk) if (tx_pop) txr <= txr + 1;

  // far-end model and monitor
  int          n_pop = 0;
  int          n_push = 0;
  int          sidx = 0;
  int          sedges = 0;
  logic [31:0] scap = '0;
  logic [31:0] slv_word = '0;
  logic        prv_sclk = 1'b0;
  logic [31:0] rx_log [4];
  logic [31:0] cap_log [4];
  int          edge_log [4];

  always @(negedge clk) begin
    int   n;
    logic lead;
    n = int'(cfg_len_m1) + 1;
    if (rst_n && (sclk !== prv_sclk)) begin
      lead = (sclk != cfg_cpol);
      if (lead) sedges = sedges + 1;
      if (lead == !cfg_cpha) scap = {scap[30:0], mosi};
      if (cfg_cpha && lead) begin
        if (sidx >= 0) miso = slv_word[sidx];
        sidx = sidx - 1;
      end
      if (!cfg_cpha && !lead) begin
        sidx = sidx - 1;
        if (sidx >= 0) miso = slv_word[sidx];
      end
    end
    if (rx_push) begin
      rx_log[n_push % 4]   = rx_data;
      cap_log[n_push % 4]  = scap;
      edge_log[n_push % 4] = sedges;
      n_push = n_push + 1;
    end
    if (tx_pop) begin
      n_pop  = n_pop + 1;
      sidx   = n - 1;
      scap   = '0;
      sedges = 0;
      if (!cfg_cpha) miso = slv_word[sidx];
    end
    prv_sclk = sclk;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_tx(input logic [31:0] w);
    txq[txw % 16] = w;
    txw = txw + 1;
  endtask

  task automatic wait_push(input int target);
    int k;
    k = 0;
    while (n_push < target && k < 2000) begin
      @(negedge clk);
      k++;
    end
    if (n_push < target) check("R5 push timeout", 32'(n_push), 32'(target));
  endtask

  function automatic logic [31:0] lmask(input logic [4:0] lm1);
    return (lm1 == 5'd31) ? 32'hFFFF_FFFF : ((32'h1 << (lm1 + 6'd1)) - 32'h1);
  endfunction

  task automatic set_cfg(input logic pol, input logic pha, input logic lp, input logic [4:0] lm1);
    enable     = 1'b0;
    @(negedge clk);
    cfg_cpol   = pol;
    cfg_cpha   = pha;
    cfg_loop   = lp;
    cfg_len_m1 = lm1;
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] m, exp;
    int base, pops0;
    rst_n = 1'b0; enable = 1'b0; cfg_loop = 1'b0; cfg_cpol = 1'b0;
    cfg_cpha = 1'b0; cfg_len_m1 = 5'd7; rx_full = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset sclk", 32'(sclk), 32'd0);
    check("R6 reset pop", 32'(tx_pop), 32'd0);
    check("R5 reset push", 32'(rx_push), 32'd0);
    check("R8 reset busy", 32'(busy), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: all modes, lengths, loopback
    for (int i = 0; i < NV; i++) begin
      set_cfg(VECS[i].cpol, VECS[i].cpha, VECS[i].loop, VECS[i].lm1);
      slv_word = VECS[i].slv;
      m    = lmask(VECS[i].lm1);
      exp  = VECS[i].loop ? (VECS[i].tx & m) : (VECS[i].slv & m);
      base = n_push;
      push_tx(VECS[i].tx);
      enable = 1'b1;
      wait_push(base + 1);
      check(VECS[i].loop ? "R3 loopback rx word" : "R2 rx word", rx_log[base % 4], exp);
      check("R4 upper bits zero", rx_log[base % 4] & ~m, 32'h0);
      check("R1 wire bits", cap_log[base % 4], VECS[i].tx & m);
      check("R1 leading edges", 32'(edge_log[base % 4]), 32'(VECS[i].lm1) + 32'd1);
      @(negedge clk);
      check("R9 rest level", 32'(sclk), 32'(VECS[i].cpol));
      check("R5 pop/push count", 32'(n_pop - n_push), 32'd0);
    end

    // idle level follows cpol
    set_cfg(1'b1, 1'b0, 1'b0, 5'd7);
    check("R9 idle high", 32'(sclk), 32'd1);
    set_cfg(1'b0, 1'b0, 1'b0, 5'd7);
    check("R9 idle low", 32'(sclk), 32'd0);

    // gating by enable and rx_full
    slv_word = 32'h5A;
    pops0 = n_pop;
    push_tx(32'h3C);
    repeat (20) @(negedge clk);
    check("R6 no pop while disabled", 32'(n_pop), 32'(pops0));
    check("R8 busy on pending", 32'(busy), 32'd1);
    rx_full = 1'b1;
    enable  = 1'b1;
    repeat (20) @(negedge clk);
    check("R6 no pop while rx full", 32'(n_pop), 32'(pops0));
    base = n_push;
    rx_full = 1'b0;
    wait_push(base + 1);
    check("R6 word after release", rx_log[base % 4], 32'h5A);

    // back-to-back burst, CPHA=1
    set_cfg(1'b0, 1'b1, 1'b0, 5'd7);
    slv_word = 32'h81;
    base = n_push;
    push_tx(32'h11); push_tx(32'h22); push_tx(32'h33);
    enable = 1'b1;
    wait_push(base + 3);
    for (int j = 0; j < 3; j++) begin
      check("R2 burst rx", rx_log[(base + j) % 4], 32'h81);
      check("R1 burst wire", cap_log[(base + j) % 4], 32'h11 * 32'(j + 1));
    end
    repeat (2) @(negedge clk);
    check("R5 burst count", 32'(n_push - base), 32'd3);
    check("R8 idle not busy", 32'(busy), 32'd0);

    // abort mid-word
    set_cfg(1'b1, 1'b0, 1'b0, 5'd31);
    push_tx(32'hCAFE_F00D);
    enable = 1'b1;
    repeat (30) @(negedge clk);
    check("R8 busy mid-word", 32'(busy), 32'd1);
    base = n_push;
    enable = 1'b0;
    @(negedge clk);
    check("R7 sclk rests after abort", 32'(sclk), 32'd1);
    repeat (200) @(negedge clk);
    check("R7 no push for aborted word", 32'(n_push), 32'(base));
    check("R8 not busy after abort", 32'(busy), 32'd0);

    // recovery
    set_cfg(1'b0, 1'b0, 1'b0, 5'd7);
    slv_word = 32'h3C;
    base = n_push;
    push_tx(32'hA5);
    enable = 1'b1;
    wait_push(base + 1);
    check("R7 recovery rx", rx_log[base % 4], 32'h3C);
    check("R7 recovery wire", cap_log[base % 4], 32'hA5);
    enable = 1'b0;
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule